// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is an SPI master that runs an external eight-input, 12-bit converter. A one-cycle `scan_start` pulse captures a channel-enable mask. The block then sends the converter a 16-bit command that selects those inputs. It follows with an all-zero filler frame, then clocks in one 16-bit result frame for each enabled input, in ascending input order. The low 12 bits of each result go into a small result array, indexed by position in the scan. When the last frame has finished, the block raises `done` for one cycle.

A `temp_start` pulse runs a different sequence for the on-chip temperature sensor. The block sends a temperature command, then a zero frame, and then waits a programmable number of clock cycles. After the wait it reads one frame and returns its low 12 bits, sign-extended to 16 bits. The `ext_ref` configuration input is merged into every command word.

The serial clock is the system clock divided by `2*CLK_DIV`. It idles low. Data leaves on the rising edge and is captured on the falling edge. Chip select is released between every pair of frames.

Top module: `adc_scan_seq`

## Requirements
- R1: The scan command word has bit 15 = 1, bit 14 = 0 and bit 0 = 0. Bit 2 carries `ext_ref`. Bit (13-n) carries `chan_mask[n]`, so input 0 maps to bit 13 and input 7 maps to bit 6. All other bits are 0.
- R2: A scan with k enabled inputs sends exactly 2+k frames: the command, an all-zero filler, then k read frames that each send all zeros. Every frame is 16 serial clocks long and sent MSB first, with data driven on the rising edge and stable across the falling edge.
- R3: `sclk` is low whenever `cs_n` is high. Between frames, `cs_n` stays high for at least `CS_GAP*2*CLK_DIV` clock cycles.
- R4: Result entry i (bits `[i*RW +: RW]` of `results`) holds the low 12 bits of the i-th read frame. Entries at or beyond the enabled count read 0. `valid_count` equals the number of set mask bits.
- R5: `busy` goes high in the cycle after a trigger is accepted and stays high for the whole sequence. `done` is a one-cycle pulse in the first cycle in which `busy` is low again.
- R6: An all-zero mask sends no frame and raises `done` within 3 cycles. It also clears all results and sets `valid_count` to 0.
- R7: A temperature read sends command 0x8022 with `ext_ref` at bit 2, then a zero frame, then waits at least `TEMP_WAIT` cycles with `cs_n` high, then runs one read frame. `temp_out` is that frame's bit 11 copied into bits 15..12, above its bits 11..0.
- R8: A trigger that arrives while `busy` is high has no effect. When `scan_start` and `temp_start` arrive together, the scan runs.
- R9: After reset, `cs_n` = 1, `sclk` = 0, `busy` = 0, `done` = 0, and `results`, `valid_count` and `temp_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_start | input | 1 | Starts a channel scan |
| temp_start | input | 1 | Starts a temperature read |
| chan_mask | input | NCH | Channel enables, bit n selects input n |
| ext_ref | input | 1 | Static reference-select bit for command words |
| miso | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to converter |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| valid_count | output | $clog2(NCH+1) | Number of stored results |
| results | output | NCH*RW | Result array, entry i at [i*RW +: RW] |
| temp_out | output | 16 | Sign-extended temperature result |

## Verification
If the sequencer state goes wrong, it shows first on the serial pins. A miscounted frame or a skipped filler changes how many chip-select pulses appear and what the first two words contain. The slave model records these words before `done` rises. A bad bit counter shows within one frame as a frame that is not 16 clocks long. A wrong result pointer or a bad clear only appears at `done`, as a misplaced or stale entry in `results`. A broken temperature wait shows as a chip-select gap that is too short.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   localparam int FRAME_W  = 16;
   localparam int WR_BIT   = 15;
   localparam int RPT_BIT  = 14;
   localparam int SEL0_BIT = 13;
   localparam int SEL_W    = 8;
   localparam int TSNS_BIT = 5;
   localparam int XREF_BIT = 2;
   localparam int TAVG_BIT = 1;
   localparam int PDN_BIT  = 0;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_CMD, SQ_FILL, SQ_READ,
      SQ_TCMD, SQ_TZERO, SQ_TWAIT, SQ_TREAD, SQ_FIN
   } seq_state_t;

   typedef enum logic [1:0] {FR_IDLE, FR_RUN, FR_GAP} frame_state_t;
endpackage

// File: rtl/adc_cmd_build.sv
module adc_cmd_build
   import adc_scan_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic [NCH-1:0]     mask,
   input  logic               xref,
   output logic [FRAME_W-1:0] scan_word,
   output logic [FRAME_W-1:0] temp_word
);
   logic [SEL_W-1:0] sel_field;

   for (genvar g = 0; g < SEL_W; g++) begin : g_sel
      if (g < NCH) begin : g_used
         assign sel_field[SEL_W-1-g] = mask[g];
      end else begin : g_pad
         assign sel_field[SEL_W-1-g] = 1'b0;
      end
   end

   always_comb begin
      scan_word                          = '0;
      scan_word[WR_BIT]                  = 1'b1;
      scan_word[RPT_BIT]                 = 1'b0;
      scan_word[SEL0_BIT -: SEL_W]       = sel_field;
      scan_word[XREF_BIT]                = xref;
      scan_word[PDN_BIT]                 = 1'b0;

      temp_word                          = '0;
      temp_word[WR_BIT]                  = 1'b1;
      temp_word[TSNS_BIT]                = 1'b1;
      temp_word[TAVG_BIT]                = 1'b1;
      temp_word[XREF_BIT]                = xref;
   end
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
   import adc_scan_pkg::*;
#(
   parameter int CLK_DIV = 2,
   parameter int CS_GAP  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic               miso,
   output logic               sclk,
   output logic               cs_n,
   output logic               mosi,
   output logic               fdone,
   output logic [FRAME_W-1:0] rx_word
);
   localparam int DIV_W   = $clog2(CLK_DIV) + 1;
   localparam int GAP_CYC = CS_GAP * 2 * CLK_DIV;
   localparam int GAP_W   = $clog2(GAP_CYC) + 1;
   localparam int EDGES   = 2 * FRAME_W;
   localparam int EDGE_W  = $clog2(EDGES) + 1;

   frame_state_t       st_q;
   logic [DIV_W-1:0]   div_q;
   logic [EDGE_W-1:0]  edge_q;
   logic [GAP_W-1:0]   gap_q;
   logic [FRAME_W-1:0] tx_q, rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FR_IDLE;
         sclk   <= 1'b0;
         cs_n   <= 1'b1;
         div_q  <= '0;
         edge_q <= '0;
         gap_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         fdone  <= 1'b0;
      end else begin
         fdone <= 1'b0;
         case (st_q)
            FR_IDLE: if (go) begin
               tx_q   <= tx_word;
               cs_n   <= 1'b0;
               div_q  <= '0;
               edge_q <= '0;
               st_q   <= FR_RUN;
            end
            FR_RUN: begin
               if (div_q == DIV_W'(CLK_DIV - 1)) begin
                  div_q <= '0;
                  if (edge_q == EDGE_W'(EDGES)) begin
                     cs_n  <= 1'b1;
                     gap_q <= '0;
                     st_q  <= FR_GAP;
                  end else begin
                     sclk   <= ~sclk;
                     edge_q <= edge_q + 1'b1;
                     if (!sclk) begin
                        if (edge_q != '0) tx_q <= tx_q << 1;
                     end else begin
                        rx_q <= {rx_q[FRAME_W-2:0], miso};
                     end
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            FR_GAP: begin
               if (gap_q == GAP_W'(GAP_CYC - 1)) begin
                  fdone <= 1'b1;
                  st_q  <= FR_IDLE;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            default: st_q <= FR_IDLE;
         endcase
      end
   end

   assign mosi    = ~cs_n & tx_q[FRAME_W-1];
   assign rx_word = rx_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int RW        = 12,
   parameter int TEMP_WAIT = 10100
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scan_start,
   input  logic                       temp_start,
   input  logic [NCH-1:0]             mask,
   input  logic [FRAME_W-1:0]         scan_word,
   input  logic [FRAME_W-1:0]         temp_word,
   input  logic                       fdone,
   input  logic [FRAME_W-1:0]         rx_word,
   output logic                       go,
   output logic [FRAME_W-1:0]         tx_word,
   output logic                       busy,
   output logic                       done,
   output logic [$clog2(NCH+1)-1:0]   valid_count,
   output logic [NCH*RW-1:0]          results,
   output logic [FRAME_W-1:0]         temp_out
);
   localparam int CNT_W  = $clog2(NCH + 1);
   localparam int WAIT_W = $clog2(TEMP_WAIT) + 1;

   seq_state_t        st_q;
   logic [CNT_W-1:0]  pos_q;
   logic [WAIT_W-1:0] wait_q;
   logic [CNT_W-1:0]  ones;
   logic              clr_res, wr_res;
   logic              unused_hi;

   always_comb begin
      ones = '0;
      for (int i = 0; i < NCH; i++) ones = ones + CNT_W'(mask[i]);
   end

   assign clr_res   = (st_q == SQ_IDLE) && scan_start;
   assign wr_res    = (st_q == SQ_READ) && fdone;
   assign busy      = (st_q != SQ_IDLE);
   assign unused_hi = ^rx_word[FRAME_W-1:RW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= SQ_IDLE;
         pos_q       <= '0;
         wait_q      <= '0;
         go          <= 1'b0;
         tx_word     <= '0;
         done        <= 1'b0;
         valid_count <= '0;
         temp_out    <= '0;
      end else begin
         go   <= 1'b0;
         done <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (scan_start) begin
                  valid_count <= ones;
                  pos_q       <= '0;
                  if (ones == '0) begin
                     st_q <= SQ_FIN;
                  end else begin
                     tx_word <= scan_word;
                     go      <= 1'b1;
                     st_q    <= SQ_CMD;
                  end
               end else if (temp_start) begin
                  tx_word <= temp_word;
                  go      <= 1'b1;
                  st_q    <= SQ_TCMD;
               end
            end
            SQ_CMD: if (fdone) begin
               tx_word <= '0;
               go      <= 1'b1;
               st_q    <= SQ_FILL;
            end
            SQ_FILL: if (fdone) begin
               go   <= 1'b1;
               st_q <= SQ_READ;
            end
            SQ_READ: if (fdone) begin
               pos_q <= pos_q + 1'b1;
               if (pos_q == valid_count - 1'b1) st_q <= SQ_FIN;
               else go <= 1'b1;
            end
            SQ_TCMD: if (fdone) begin
               tx_word <= '0;
               go      <= 1'b1;
               st_q    <= SQ_TZERO;
            end
            SQ_TZERO: if (fdone) begin
               wait_q <= '0;
               st_q   <= SQ_TWAIT;
            end
            SQ_TWAIT: begin
               if (wait_q == WAIT_W'(TEMP_WAIT - 1)) begin
                  go   <= 1'b1;
                  st_q <= SQ_TREAD;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            SQ_TREAD: if (fdone) begin
               temp_out <= {{(FRAME_W-RW){rx_word[RW-1]}}, rx_word[RW-1:0]};
               st_q     <= SQ_FIN;
            end
            SQ_FIN: begin
               done <= 1'b1;
               st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   for (genvar e = 0; e < NCH; e++) begin : g_slot
      logic [RW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  slot_q <= '0;
         else if (clr_res)                            slot_q <= '0;
         else if (wr_res && pos_q == CNT_W'(e))       slot_q <= rx_word[RW-1:0];
      end
      assign results[e*RW +: RW] = slot_q;
   end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int RW        = 12,
   parameter int CLK_DIV   = 2,
   parameter int CS_GAP    = 2,
   parameter int TEMP_WAIT = 10100
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scan_start,
   input  logic                     temp_start,
   input  logic [NCH-1:0]           chan_mask,
   input  logic                     ext_ref,
   input  logic                     miso,
   output logic                     sclk,
   output logic                     cs_n,
   output logic                     mosi,
   output logic                     busy,
   output logic                     done,
   output logic [$clog2(NCH+1)-1:0] valid_count,
   output logic [NCH*RW-1:0]        results,
   output logic [FRAME_W-1:0]       temp_out
);
   if (NCH < 1 || NCH > SEL_W) begin : g_bad_nch
      $error("adc_scan_seq: NCH must be 1..8");
   end
   if (RW < 2 || RW >= FRAME_W) begin : g_bad_rw
      $error("adc_scan_seq: RW must be 2..15");
   end
   if (CLK_DIV < 1 || CS_GAP < 1 || TEMP_WAIT < 1) begin : g_bad_tim
      $error("adc_scan_seq: timing parameters must be positive");
   end

   logic [FRAME_W-1:0] scan_word, temp_word, tx_word, rx_word;
   logic               go, fdone;

   adc_cmd_build #(.NCH(NCH)) cmd_i (
      .mask      (chan_mask),
      .xref      (ext_ref),
      .scan_word (scan_word),
      .temp_word (temp_word)
   );

   adc_seq_ctrl #(.NCH(NCH), .RW(RW), .TEMP_WAIT(TEMP_WAIT)) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scan_start  (scan_start),
      .temp_start  (temp_start),
      .mask        (chan_mask),
      .scan_word   (scan_word),
      .temp_word   (temp_word),
      .fdone       (fdone),
      .rx_word     (rx_word),
      .go          (go),
      .tx_word     (tx_word),
      .busy        (busy),
      .done        (done),
      .valid_count (valid_count),
      .results     (results),
      .temp_out    (temp_out)
   );

   adc_spi_frame #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) frame_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .tx_word (tx_word),
      .miso    (miso),
      .sclk    (sclk),
      .cs_n    (cs_n),
      .mosi    (mosi),
      .fdone   (fdone),
      .rx_word (rx_word)
   );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter int NCH = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sclk,
   input logic                     cs_n,
   input logic                     mosi,
   input logic                     busy,
   input logic                     done,
   input logic [$clog2(NCH+1)-1:0] valid_count
);
   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R3
   cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);

   // R2
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !$rose(sclk)) |-> $stable(mosi));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R4
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_count <= ($clog2(NCH+1))'(NCH));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sclk        (sclk),
   .cs_n        (cs_n),
   .mosi        (mosi),
   .busy        (busy),
   .done        (done),
   .valid_count (valid_count)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb_top;
   localparam int NCH       = 8;
   localparam int RW        = 12;
   localparam int CLK_DIV   = 2;
   localparam int CS_GAP    = 2;
   localparam int TEMP_WAIT = 400;
   localparam int GAP_CYC   = CS_GAP * 2 * CLK_DIV;

   // 100 MHz: 10 time units per period
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, scan_start = 1'b0, temp_start = 1'b0, ext_ref = 1'b0;
   logic [NCH-1:0] chan_mask = '0;
   logic miso = 1'b0;
   logic sclk, cs_n, mosi, busy, done;
   logic [3:0] valid_count;
   logic [NCH*RW-1:0] results;
   logic [15:0] temp_out;

   adc_scan_seq #(.NCH(NCH), .RW(RW), .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP),
                  .TEMP_WAIT(TEMP_WAIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .temp_start(temp_start),
      .chan_mask(chan_mask), .ext_ref(ext_ref), .miso(miso), .sclk(sclk),
      .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done),
      .valid_count(valid_count), .results(results), .temp_out(temp_out));

   // converter model
   int fcount = 0;
   logic [15:0] got [0:15];
   logic [15:0] reply [0:15];
   int nbits [0:15];
   longint t_fall [0:15];
   longint t_rise [0:15];
   logic [15:0] s_out = '0, s_in = '0;
   bit in_fr = 0;

   always @(negedge cs_n) begin
      in_fr = 1; s_in = '0; s_out = reply[fcount % 16];
      if (fcount < 16) begin nbits[fcount] = 0; t_fall[fcount] = longint'($time); end
   end
   always @(posedge sclk) if (!cs_n) begin miso = s_out[15]; s_out = s_out << 1; end
   always @(negedge sclk) if (!cs_n) begin
      s_in = {s_in[14:0], mosi};
      if (fcount < 16) nbits[fcount]++;
   end
   always @(posedge cs_n) if (in_fr) begin
      in_fr = 0;
      if (fcount < 16) begin got[fcount] = s_in; t_rise[fcount] = longint'($time); end
      fcount++;
   end

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_cmd(logic [7:0] m, logic x);
      logic [15:0] w = 16'h8000;
      for (int n = 0; n < 8; n++) if (m[n]) w[13-n] = 1'b1;
      w[2] = x;
      return w;
   endfunction

   function automatic int ones8(logic [7:0] m);
      int c = 0;
      for (int n = 0; n < 8; n++) c += int'(m[n]);
      return c;
   endfunction

   task automatic pulse(logic s, logic t, logic [7:0] m, logic x);
      @(negedge clk);
      chan_mask = m; ext_ref = x; scan_start = s; temp_start = t;
      @(negedge clk);
      scan_start = 1'b0; temp_start = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 1;
      while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
   endtask

   task automatic check_scan(logic [7:0] m, logic x);
      int k = ones8(m);
      chk("R2", "frame count", 32'(fcount), 32'(k == 0 ? 0 : 2 + k));
      if (k > 0) begin
         chk("R1", "command word", 32'(got[0]), 32'(exp_cmd(m, x)));
         for (int f = 1; f < 2 + k; f++) begin
            chk("R2", "zero tx word", 32'(got[f]), 32'h0);
            chk("R2", "bits per frame", 32'(nbits[f]), 32'd16);
         end
         for (int f = 0; f < 1 + k; f++)
            chk("R3", "cs gap ok", 32'((t_fall[f+1] - t_rise[f]) >= longint'(GAP_CYC * 10)), 32'd1);
      end
      chk("R4", "valid count", 32'(valid_count), 32'(k));
      for (int e = 0; e < NCH; e++)
         chk("R4", "result entry", 32'(results[e*RW +: RW]),
             e < k ? 32'(reply[2+e][11:0]) : 32'h0);
   endtask

   task automatic run_scan(logic [7:0] m, logic x);
      int cyc;
      for (int f = 0; f < 16; f++) reply[f] = 16'($urandom);
      fcount = 0;
      pulse(1'b1, 1'b0, m, x);
      chk("R5", "busy after trigger", 32'(busy), 32'd1);
      wait_done(cyc);
      chk("R5", "busy low at done", 32'(busy), 32'd0);
      if (m == 8'h00) chk("R6", "zero mask fast done", 32'(cyc <= 3), 32'd1);
      check_scan(m, x);
      @(negedge clk);
      chk("R5", "done single cycle", 32'(done), 32'd0);
   endtask

   task automatic run_temp(logic x, logic [15:0] r);
      int cyc;
      reply[0] = 16'hFFFF; reply[1] = 16'hFFFF; reply[2] = r;
      fcount = 0;
      pulse(1'b0, 1'b1, 8'h5A, x);
      wait_done(cyc);
      chk("R7", "frame count", 32'(fcount), 32'd3);
      chk("R7", "temp command", 32'(got[0]), 32'(16'h8022 | (16'(x) << 2)));
      chk("R7", "zero frame", 32'(got[1]), 32'h0);
      chk("R7", "wait length ok",
          32'((t_fall[2] - t_rise[1]) >= longint'(TEMP_WAIT * 10)), 32'd1);
      chk("R7", "sign extended", 32'(temp_out), 32'({{4{r[11]}}, r[11:0]}));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int cyc;
      void'($urandom(32'h1D5E_0A7C));
      for (int f = 0; f < 16; f++) reply[f] = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "cs_n", 32'(cs_n), 32'd1);
      chk("R9", "sclk", 32'(sclk), 32'd0);
      chk("R9", "busy", 32'(busy), 32'd0);
      chk("R9", "done", 32'(done), 32'd0);
      chk("R9", "results", 32'(|results), 32'd0);
      chk("R9", "valid_count", 32'(valid_count), 32'd0);
      chk("R9", "temp_out", 32'(temp_out), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_scan(8'h01, 1'b0);
      run_scan(8'h80, 1'b1);
      run_scan(8'hFF, 1'b0);
      run_scan(8'hA5, 1'b1);
      run_scan(8'h00, 1'b1);   // R6
      for (int it = 0; it < 14; it++)
         run_scan(8'($urandom), 1'($urandom));

      run_temp(1'b0, 16'hFA05);
      run_temp(1'b1, 16'h37FF);
      run_temp(1'b0, 16'h0800);

      // R8: triggers during a scan are ignored
      for (int f = 0; f < 16; f++) reply[f] = 16'($urandom);
      fcount = 0;
      pulse(1'b1, 1'b0, 8'h81, 1'b0);
      repeat (20) @(negedge clk);
      pulse(1'b1, 1'b1, 8'hFF, 1'b1);
      wait_done(cyc);
      repeat (300) @(negedge clk);
      chk("R8", "no extra frames", 32'(fcount), 32'd4);
      chk("R8", "command kept", 32'(got[0]), 32'(exp_cmd(8'h81, 1'b0)));
      chk("R8", "count kept", 32'(valid_count), 32'd2);

      // R8: simultaneous triggers, scan wins
      for (int f = 0; f < 16; f++) reply[f] = 16'($urandom);
      fcount = 0;
      pulse(1'b1, 1'b1, 8'h18, 1'b0);
      wait_done(cyc);
      chk("R8", "scan priority frames", 32'(fcount), 32'd4);
      check_scan(8'h18, 1'b0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule